// File: doc/BRIEF.md
# DRAM Refresh and Start-up Sequencer

This block keeps an asynchronous DRAM alive and brings it up correctly. After reset it holds the memory quiet for a power-on pause, and then runs a fixed number of dummy RAS cycles. Only after that does it announce readiness and let the host access controller in. From then on it spreads refreshes evenly in time, so that every one of the 2^ROW_W rows is refreshed once per retention period.

The host side is a plain request/grant pair. The host raises `host_req` and owns the DRAM bus while `host_gnt` is high. The grant is kept for as long as the request stays high, so a long transfer is never cut short. Refreshes that come due during such a transfer are counted, up to `MAX_OWED`, and are issued back to back once the host lets go. A new grant is given only when no refresh is owed.

While it owns the bus (`bus_own` high), the block drives the strobes itself. A parameter selects the refresh style. In CAS-before-RAS style, CAS falls ahead of RAS and the memory supplies its own row. In RAS-only style, RAS is strobed with CAS high and the block presents the row from its own counter. A `reinit_req` pulse repeats the whole pause and dummy-cycle sequence, as is needed after the strobes have been stopped for longer than the retention period.

Top module: `dram_upkeep`

## Requirements
- R1: While reset is held, `ras_n` and `cas_n` are 1, `host_gnt`, `init_done` and `bus_own` are 0, and `row_addr` is 0.
- R2: After reset release, and after an accepted `reinit_req`, the first RAS falling edge comes no earlier than `PAUSE_CYC` cycles later.
- R3: After the pause, exactly `INIT_CYC` RAS cycles run, and then `init_done` is high for exactly one cycle.
- R4: `host_gnt` stays 0 until `init_done` has pulsed. It rises one cycle after a cycle in which `host_req` is high, the block is idle and no refresh is owed. It then holds while `host_req` stays high, and it falls at the first clock edge that samples `host_req` low.
- R5: While `host_gnt` is 1, `ras_n` and `cas_n` are 1 and `bus_own` is 0.
- R6: With no host activity, successive RAS falling edges are exactly `REF_CYC` cycles apart.
- R7: Refreshes that come due while the host holds the bus are counted up to `MAX_OWED`. On release, exactly that many are issued back to back before the next interval expires.
- R8: In CAS-before-RAS style, CAS is low for exactly `T_CSR` cycles before RAS falls, has been high for at least `T_PRE` cycles before it falls, and stays low for exactly `T_CHR` cycles counted from the RAS fall.
- R9: Every RAS low pulse lasts exactly `T_ACT` cycles. RAS is high for at least `T_PRE` cycles before each fall, plus `T_CSR` more in CAS-before-RAS style.
- R10: In RAS-only style, CAS stays 1. `row_addr` is 0 at the first RAS fall after reset, goes up by one per RAS cycle and wraps at 2^ROW_W, and does not change while RAS is low.
- R11: A `reinit_req` pulse, once the host has released the bus and any running cycle has ended, repeats the pause and the initialization cycles, and `init_done` pulses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host asks for the DRAM bus |
| reinit_req | input | 1 | One-cycle pulse that repeats the start-up sequence |
| host_gnt | output | 1 | Host owns the DRAM bus |
| init_done | output | 1 | One-cycle pulse when start-up has completed |
| bus_own | output | 1 | This block is driving the strobes and the row address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_W | Row for RAS-only refresh (0 in CAS-before-RAS style) |

## Verification
A refresh that comes due at the last count of the interval timer shows as a RAS fall 1 + `T_PRE` (+ `T_CSR`) cycles later. The grant follows the request by one edge and is withdrawn at the edge after the request drops. `init_done` appears in the first cycle in which RAS is high again after the last initialization cycle. The bench drives inputs 1 ns after the rising edge and samples every output at the falling edge. Per-instance monitors measure each pulse and gap in whole sampled cycles against the parameter values, and the back-to-back burst is counted in a fixed 28-cycle window that starts at the release. That window lies well before the next interval expiry for both refresh styles.

// File: rtl/dram_upkeep_pkg.sv
package dram_upkeep_pkg;
  typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_RUN} upkeep_phase_t;
  typedef enum logic [1:0] {ES_IDLE, ES_PRE, ES_CSET, ES_ACT} strobe_state_t;
endpackage

// File: rtl/upkeep_interval.sv
module upkeep_interval #(
  parameter int REF_CYC  = 1562,
  parameter int MAX_OWED = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic take,
  output logic owed_any
);
  localparam int RW = $clog2(REF_CYC + 1);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [RW-1:0] tcnt_q;
  logic [OW-1:0] owed_q;
  logic          tick;

  assign tick     = run && (tcnt_q == RW'(REF_CYC - 1));
  assign owed_any = (owed_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      tcnt_q <= '0;
      owed_q <= '0;
    end else begin
      tcnt_q <= tick ? '0 : tcnt_q + 1'b1;
      case ({tick, take})
        2'b10:   if (owed_q != OW'(MAX_OWED)) owed_q <= owed_q + 1'b1;
        2'b01:   owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end

  AST_OWED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OW'(MAX_OWED)); // R7
  AST_TAKE_NEEDS_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && run) |-> owed_any); // R7
endmodule

// File: rtl/upkeep_startup.sv
module upkeep_startup import dram_upkeep_pkg::*; #(
  parameter int PAUSE_CYC = 20000,
  parameter int INIT_CYC  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic cyc_done,
  output logic want_cycle,
  output logic running,
  output logic init_done
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INIT_CYC + 1);

  upkeep_phase_t phase_q;
  logic [PW-1:0] pcnt_q;
  logic [IW-1:0] icnt_q;
  logic          done_q;

  assign want_cycle = (phase_q == PH_INIT);
  assign running    = (phase_q == PH_RUN);
  assign init_done  = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      phase_q <= PH_PAUSE;
      pcnt_q  <= '0;
      icnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_PAUSE: begin
          if (pcnt_q == PW'(PAUSE_CYC - 1)) phase_q <= PH_INIT;
          else pcnt_q <= pcnt_q + 1'b1;
        end
        PH_INIT: begin
          if (cyc_done) begin
            if (icnt_q == IW'(INIT_CYC - 1)) begin
              phase_q <= PH_RUN;
              done_q  <= 1'b1;
            end
            icnt_q <= icnt_q + 1'b1;
          end
        end
        default: phase_q <= phase_q;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3
endmodule

// File: rtl/upkeep_strobe_engine.sv
module upkeep_strobe_engine import dram_upkeep_pkg::*; #(
  parameter bit USE_CBR = 1'b1,
  parameter int ROW_W   = 8,
  parameter int T_PRE   = 2,
  parameter int T_CSR   = 1,
  parameter int T_CHR   = 2,
  parameter int T_ACT   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row,
  output logic             busy,
  output logic             done
);
  localparam int TM1 = (T_PRE > T_CSR) ? T_PRE : T_CSR;
  localparam int TM2 = (T_ACT > TM1) ? T_ACT : TM1;
  localparam int CW  = $clog2(TM2 + 1);

  strobe_state_t state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] span;
  logic          last;

  always_comb begin
    case (state_q)
      ES_PRE:  span = CW'(T_PRE - 1);
      ES_CSET: span = CW'(T_CSR - 1);
      ES_ACT:  span = CW'(T_ACT - 1);
      default: span = '0;
    endcase
  end

  assign last = (cnt_q == span);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ES_IDLE: if (start) state_d = ES_PRE;
      ES_PRE:  if (last) state_d = USE_CBR ? ES_CSET : ES_ACT;
      ES_CSET: if (last) state_d = ES_ACT;
      ES_ACT:  if (last) state_d = ES_IDLE;
      default: state_d = ES_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ES_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
    end
  end

  assign busy  = (state_q != ES_IDLE);
  assign done  = (state_q == ES_ACT) && last;
  assign ras_n = (state_q != ES_ACT);

  generate
    if (USE_CBR) begin : g_cbr
      assign cas_n = !((state_q == ES_CSET) ||
                       ((state_q == ES_ACT) && (cnt_q < CW'(T_CHR))));
      assign row   = '0;

      AST_CAS_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R8
    end else begin : g_ras_only
      logic [ROW_W-1:0] row_q;
      always_ff @(posedge clk) begin
        if (!rst_n) row_q <= '0;
        else if (done) row_q <= row_q + 1'b1;
      end
      assign row   = row_q;
      assign cas_n = 1'b1;

      AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (row_q == ROW_W'($past(row_q) + 1'b1))); // R10
      AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n)) |-> $stable(row_q)); // R10
    end
  endgenerate
endmodule

// File: rtl/dram_upkeep.sv
module dram_upkeep import dram_upkeep_pkg::*; #(
  parameter int ROW_W     = 8,
  parameter bit USE_CBR   = 1'b1,
  parameter int CLK_KHZ   = 100000,
  parameter int PAUSE_CYC = CLK_KHZ / 5,
  parameter int REF_CYC   = (CLK_KHZ * 4) / (2 ** ROW_W),
  parameter int INIT_CYC  = 8,
  parameter int MAX_OWED  = 4,
  parameter int T_PRE     = 2,
  parameter int T_CSR     = 1,
  parameter int T_CHR     = 2,
  parameter int T_ACT     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             reinit_req,
  output logic             host_gnt,
  output logic             init_done,
  output logic             bus_own,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row_addr
);
  logic gnt_q, reinit_q;
  logic busy, cyc_done, want_cycle, running, owed_any;
  logic launch, take_reinit;

  assign take_reinit = reinit_q && !busy && !gnt_q;
  assign launch      = !busy && !gnt_q && !reinit_q &&
                       (want_cycle || (running && owed_any));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q    <= 1'b0;
      reinit_q <= 1'b0;
    end else begin
      if (reinit_req) reinit_q <= 1'b1;
      else if (take_reinit) reinit_q <= 1'b0;

      if (!host_req) gnt_q <= 1'b0;
      else if (running && !busy && !owed_any && !reinit_q) gnt_q <= 1'b1;
    end
  end

  upkeep_startup #(.PAUSE_CYC(PAUSE_CYC), .INIT_CYC(INIT_CYC)) u_start (
    .clk(clk), .rst_n(rst_n), .restart(take_reinit), .cyc_done(cyc_done),
    .want_cycle(want_cycle), .running(running), .init_done(init_done)
  );

  upkeep_interval #(.REF_CYC(REF_CYC), .MAX_OWED(MAX_OWED)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(running), .take(launch),
    .owed_any(owed_any)
  );

  upkeep_strobe_engine #(
    .USE_CBR(USE_CBR), .ROW_W(ROW_W), .T_PRE(T_PRE), .T_CSR(T_CSR),
    .T_CHR(T_CHR), .T_ACT(T_ACT)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start(launch), .ras_n(ras_n), .cas_n(cas_n),
    .row(row_addr), .busy(busy), .done(cyc_done)
  );

  assign host_gnt = gnt_q;
  assign bus_own  = busy;

  AST_GNT_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> running); // R4
  AST_QUIET_WHEN_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> (ras_n && cas_n && !bus_own)); // R5
  AST_GNT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req |=> !host_gnt); // R4
endmodule

// File: tb/dram_upkeep_test.sv
module upkeep_watch #(
  parameter bit CBR      = 1'b1,
  parameter int ROW_W    = 8,
  parameter int PAUSE    = 30,
  parameter int INIT_CYC = 8,
  parameter int REF      = 80,
  parameter int MAX_OWED = 3,
  parameter int T_PRE    = 2,
  parameter int T_CSR    = 1,
  parameter int T_CHR    = 2,
  parameter int T_ACT    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             bus_own,
  input logic             host_gnt,
  input logic             init_done,
  input logic [ROW_W-1:0] row_addr,
  input logic             reinit_req,
  input logic             cadence_on,
  input logic             burst_arm
);
  int n_chk, n_bad, cyc, seg_start, seg_falls, done_cnt, cad_n, falls_total;
  int ras_hi_run, ras_lo_run, cas_lo_run, cas_hi_run, cas_hi_at_fall, cas_lo_act;
  int exp_row, held_row, last_fall, burst_start, burst_falls;
  bit seg_done, prev_ras, prev_cas, prev_done, cad_valid, burst_on;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (%s): got %0d want %0d at cycle %0d", req, CBR ? "cbr" : "ras-only", act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; seg_start = 0; seg_falls = 0; seg_done = 0;
      prev_ras = 1; prev_cas = 1; prev_done = 0;
      ras_hi_run = 1000; ras_lo_run = 0; cas_lo_run = 0; cas_hi_run = 1000;
      cas_hi_at_fall = 0; cas_lo_act = 0; exp_row = 0; held_row = 0;
      cad_valid = 0; burst_on = 0;
    end else begin
      cyc++;
      if (reinit_req) begin seg_start = cyc; seg_falls = 0; seg_done = 0; end
      if (burst_arm) begin burst_on = 1; burst_start = cyc; burst_falls = 0; end
      if (host_gnt) chk(ras_n && cas_n && !bus_own, "R5", {ras_n, cas_n, bus_own}, 3'b110);
      if (!seg_done) chk(!host_gnt, "R4", host_gnt, 0);
      if (prev_done) chk(!init_done, "R3", init_done, 0);
      if (init_done && !prev_done) begin
        chk(seg_falls == INIT_CYC, "R3", seg_falls, INIT_CYC);
        seg_done = 1;
        done_cnt++;
      end
      if (prev_ras && !ras_n) begin
        chk(ras_hi_run >= T_PRE + (CBR ? T_CSR : 0), "R9", ras_hi_run, T_PRE + (CBR ? T_CSR : 0));
        if (CBR) begin
          chk(cas_lo_run == T_CSR, "R8", cas_lo_run, T_CSR);
          chk(cas_hi_at_fall >= T_PRE, "R8", cas_hi_at_fall, T_PRE);
        end else begin
          chk(cas_n == 1'b1, "R10", cas_n, 1);
          chk(int'(row_addr) == exp_row, "R10", row_addr, exp_row);
          held_row = row_addr;
          exp_row = (exp_row + 1) % (1 << ROW_W);
        end
        if (seg_falls == 0) chk(cyc - seg_start >= PAUSE, "R2", cyc - seg_start, PAUSE);
        seg_falls++;
        falls_total++;
        if (cadence_on) begin
          if (cad_valid) begin
            chk(cyc - last_fall == REF, "R6", cyc - last_fall, REF);
            cad_n++;
          end
          cad_valid = 1;
          last_fall = cyc;
        end else cad_valid = 0;
        if (burst_on) burst_falls++;
        ras_lo_run = 0;
        cas_lo_act = 0;
      end
      if (!ras_n) begin
        ras_lo_run++;
        if (!cas_n) cas_lo_act++;
        if (!CBR) chk(int'(row_addr) == held_row, "R10", row_addr, held_row);
      end
      if (!prev_ras && ras_n) begin
        chk(ras_lo_run == T_ACT, "R9", ras_lo_run, T_ACT);
        if (CBR) chk(cas_lo_act == T_CHR, "R8", cas_lo_act, T_CHR);
      end
      if (!CBR) chk(cas_n == 1'b1, "R10", cas_n, 1);
      if (prev_cas && !cas_n) cas_hi_at_fall = cas_hi_run;
      if (burst_on && cyc - burst_start == 28) begin
        chk(burst_falls == MAX_OWED, "R7", burst_falls, MAX_OWED);
        burst_on = 0;
      end
      if (ras_n) ras_hi_run++; else ras_hi_run = 0;
      if (cas_n) begin cas_hi_run++; cas_lo_run = 0; end
      else begin cas_lo_run++; cas_hi_run = 0; end
      prev_ras = ras_n;
      prev_cas = cas_n;
      prev_done = init_done;
    end
  end
endmodule

module dram_upkeep_test;
  localparam int ROW_W = 8, PAUSE = 30, INIT_CYC = 8, REF = 80, MAX_OWED = 3;
  localparam int T_PRE = 2, T_CSR = 1, T_CHR = 2, T_ACT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b1;
  logic reinit_req = 1'b0;
  logic cadence_on = 1'b0;
  logic burst_arm = 1'b0;

  logic gnt_c, done_c, own_c, ras_c, cas_c;
  logic gnt_r, done_r, own_r, ras_r, cas_r;
  logic [ROW_W-1:0] row_c, row_r;

  int n_chk = 0, n_bad = 0, cycles = 0;

  always #2 clk = ~clk;

  dram_upkeep #(.ROW_W(ROW_W), .USE_CBR(1'b1), .PAUSE_CYC(PAUSE), .REF_CYC(REF),
    .INIT_CYC(INIT_CYC), .MAX_OWED(MAX_OWED), .T_PRE(T_PRE), .T_CSR(T_CSR),
    .T_CHR(T_CHR), .T_ACT(T_ACT)) uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .reinit_req(reinit_req),
    .host_gnt(gnt_c), .init_done(done_c), .bus_own(own_c), .ras_n(ras_c),
    .cas_n(cas_c), .row_addr(row_c));

  dram_upkeep #(.ROW_W(ROW_W), .USE_CBR(1'b0), .PAUSE_CYC(PAUSE), .REF_CYC(REF),
    .INIT_CYC(INIT_CYC), .MAX_OWED(MAX_OWED), .T_PRE(T_PRE), .T_CSR(T_CSR),
    .T_CHR(T_CHR), .T_ACT(T_ACT)) uut_ro (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .reinit_req(reinit_req),
    .host_gnt(gnt_r), .init_done(done_r), .bus_own(own_r), .ras_n(ras_r),
    .cas_n(cas_r), .row_addr(row_r));

  upkeep_watch #(.CBR(1'b1), .ROW_W(ROW_W), .PAUSE(PAUSE), .INIT_CYC(INIT_CYC),
    .REF(REF), .MAX_OWED(MAX_OWED), .T_PRE(T_PRE), .T_CSR(T_CSR), .T_CHR(T_CHR),
    .T_ACT(T_ACT)) mon_c (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_c), .cas_n(cas_c), .bus_own(own_c),
    .host_gnt(gnt_c), .init_done(done_c), .row_addr(row_c), .reinit_req(reinit_req),
    .cadence_on(cadence_on), .burst_arm(burst_arm));

  upkeep_watch #(.CBR(1'b0), .ROW_W(ROW_W), .PAUSE(PAUSE), .INIT_CYC(INIT_CYC),
    .REF(REF), .MAX_OWED(MAX_OWED), .T_PRE(T_PRE), .T_CSR(T_CSR), .T_CHR(T_CHR),
    .T_ACT(T_ACT)) mon_r (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_r), .cas_n(cas_r), .bus_own(own_r),
    .host_gnt(gnt_r), .init_done(done_r), .row_addr(row_r), .reinit_req(reinit_req),
    .cadence_on(cadence_on), .burst_arm(burst_arm));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d want %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d",
             n_chk + mon_c.n_chk + mon_r.n_chk, n_bad + mon_c.n_bad + mon_r.n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles want under 150000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state of both styles
    chk(ras_c && cas_c, "R1 strobes cbr", {ras_c, cas_c}, 3);
    chk(ras_r && cas_r, "R1 strobes ras-only", {ras_r, cas_r}, 3);
    chk(!gnt_c && !gnt_r, "R1 grant", {gnt_c, gnt_r}, 0);
    chk(!done_c && !done_r, "R1 init_done", {done_c, done_r}, 0);
    chk(!own_c && !own_r, "R1 bus_own", {own_c, own_r}, 0);
    chk(row_c == '0 && row_r == '0, "R1 row", row_r, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2, R3, R4: host requests from the start; no grant until start-up ends
    do @(negedge clk); while (!done_c);
    @(posedge clk); #1;
    @(negedge clk);
    chk(gnt_c == 1'b1, "R4 grant after init cbr", gnt_c, 1);
    chk(gnt_r == 1'b1, "R4 grant after init ras-only", gnt_r, 1);

    // R7: hold the bus across five interval expiries, then release mid-interval
    repeat (438) @(posedge clk);
    #1 host_req = 1'b0; burst_arm = 1'b1;
    @(posedge clk); #1 burst_arm = 1'b0;
    chk(gnt_c == 1'b0, "R4 grant drop cbr", gnt_c, 0);
    chk(gnt_r == 1'b0, "R4 grant drop ras-only", gnt_r, 0);

    // R6, R10: free-running cadence long enough for the row counter to wrap
    repeat (2 * REF) @(posedge clk);
    #1 cadence_on = 1'b1;
    repeat (265 * REF) @(posedge clk);
    #1 cadence_on = 1'b0;
    chk(mon_c.cad_n >= 200, "R6 cadence samples cbr", mon_c.cad_n, 200);
    chk(mon_r.cad_n >= 200, "R6 cadence samples ras-only", mon_r.cad_n, 200);
    chk(mon_r.falls_total > (1 << ROW_W), "R10 row wrap reached", mon_r.falls_total, 1 << ROW_W);

    // R11: repeat start-up away from any refresh
    do @(negedge clk); while (ras_c);
    repeat (20) @(posedge clk);
    #1 reinit_req = 1'b1;
    @(posedge clk); #1 reinit_req = 1'b0;
    repeat (PAUSE + INIT_CYC * 10 + 20) @(negedge clk);
    chk(mon_c.done_cnt == 2, "R11 second init cbr", mon_c.done_cnt, 2);
    chk(mon_r.done_cnt == 2, "R11 second init ras-only", mon_r.done_cnt, 2);
    chk(mon_c.seg_done && mon_r.seg_done, "R11 both ready", {mon_c.seg_done, mon_r.seg_done}, 3);
    finish_run();
  end
endmodule